// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block inspects the destination address of every incoming frame and decides whether the frame is kept. For each address presented with a valid strobe, it produces a registered accept flag. It also produces a two-bit destination class code that the receive path places in its status word. A class code of zero means the frame was rejected.

The filter has two sources of configuration. A control register holds a global enable and four accept modes: all broadcast, all multicast, all unicast, and perfect match against the station address. The station address is loaded as 16-bit words through an indexed data port. The word index is taken from the low bits of the control register.

Configuration can change only while the filter is disabled. Software first clears the enable bit. It then writes the new modes and station words, and finally sets the enable bit again. Promiscuous operation is switched by changing only the accept-all-unicast mode through this same sequence.

Top module: `rx_dest_filter`

## Requirements
- R1: An all-ones destination is broadcast. Any other destination whose byte 0 has bit 0 set (dst_addr[0], where byte i sits at dst_addr[8i+7:8i]) is multicast. Every other destination is unicast. An accepted frame reports class 3 for broadcast, 2 for multicast and 1 for unicast.
- R2: A rejected frame reports accept=0 and class 0.
- R3: While the enable bit (control bit 31) is 0, every frame is rejected.
- R4: With enable set, a broadcast frame is accepted exactly when control bit 30 is set.
- R5: With enable set, a multicast frame is accepted exactly when control bit 29 is set.
- R6: With enable set, a unicast frame is accepted when control bit 28 is set, or when control bit 27 is set and the destination equals the station address.
- R7: A data-port write stores its 16 bits into the station word selected by control bits 9:0. Index 0 holds bytes 0 and 1, index 2 holds bytes 2 and 3, and index 4 holds bytes 4 and 5. Within a word, bits 7:0 hold the lower-numbered byte. Any other index stores nothing.
- R8: Data-port writes are ignored while enable is 1.
- R9: A control write made while enable is 1 changes only the enable bit. Mode bits and index keep their values.
- R10: Accept and class update on the clock edge that samples dst_valid=1 and hold their values while dst_valid is 0.
- R11: After reset, accept is 0, class is 0, all control fields are 0 and the station address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dst_valid | input | 1 | Destination address valid strobe |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| data_wr | input | 1 | Station data port write strobe |
| data_wdata | input | 16 | Station data port write word |
| accept | output | 1 | Frame accepted |
| dest_class | output | 2 | Destination class, 0 when rejected |

## Verification
The bench builds the block with its default parameters: a 6-byte address, a 16-bit data port, a 32-bit control word and a 10-bit index field. With these values all three station words can be written. The unused indices 1, 3 and 5 and indices beyond the last word can also be reached. Random index values in the 0 to 7 range cover both the valid and the ignored slots. Perfect-match frames and single-bit-flipped neighbours of the station address show whether every station byte lands in its correct position.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    CLS_REJECT = 2'd0,
    CLS_UNI    = 2'd1,
    CLS_MULTI  = 2'd2,
    CLS_BCAST  = 2'd3
  } dclass_e;

  // control bit positions (decoded by software, so kept fixed)
  localparam int unsigned BIT_EN  = 31;
  localparam int unsigned BIT_AAB = 30;
  localparam int unsigned BIT_AAM = 29;
  localparam int unsigned BIT_AAU = 28;
  localparam int unsigned BIT_APM = 27;

  typedef struct packed {
    logic en;
    logic all_bcast;
    logic all_mcast;
    logic all_ucast;
    logic perfect;
  } mode_t;

endpackage

// File: rtl/rxf_ctrl_regs.sv
module rxf_ctrl_regs
  import rxf_pkg::*;
#(
  parameter int unsigned CTRL_W    = 32,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned MAC_BYTES = 6,
  localparam int unsigned MAC_W    = MAC_BYTES * 8,
  localparam int unsigned NWORDS   = MAC_W / PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              data_wr,
  input  logic [PORT_W-1:0] data_wdata,
  output mode_t             mode,
  output logic [MAC_W-1:0]  station
);

  logic [IDX_W-1:0] idx_q;

  // mode and index: full load only while disabled, else enable bit alone
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      idx_q <= '0;
    end else if (ctrl_wr) begin
      if (!mode.en) begin
        mode.en        <= ctrl_wdata[BIT_EN];
        mode.all_bcast <= ctrl_wdata[BIT_AAB];
        mode.all_mcast <= ctrl_wdata[BIT_AAM];
        mode.all_ucast <= ctrl_wdata[BIT_AAU];
        mode.perfect   <= ctrl_wdata[BIT_APM];
        idx_q          <= ctrl_wdata[IDX_W-1:0];
      end else begin
        mode.en <= ctrl_wdata[BIT_EN];
      end
    end
  end

  // one storage word per even index
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(2 * k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        station[k*PORT_W +: PORT_W] <= '0;
      else if (data_wr && !mode.en && idx_q == SLOT)
        station[k*PORT_W +: PORT_W] <= data_wdata;
    end
  end

endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
  import rxf_pkg::*;
#(
  parameter int unsigned MAC_BYTES = 6,
  localparam int unsigned MAC_W    = MAC_BYTES * 8
) (
  input  logic [MAC_W-1:0] addr,
  input  logic [MAC_W-1:0] station,
  input  mode_t            mode,
  output logic             hit,
  output dclass_e          cls
);

  function automatic dclass_e kind_of(input logic [MAC_W-1:0] a);
    if (&a)       return CLS_BCAST;
    else if (a[0]) return CLS_MULTI;
    else          return CLS_UNI;
  endfunction

  dclass_e kind;
  logic    match;

  always_comb begin
    kind  = kind_of(addr);
    match = (addr == station);
    unique case (kind)
      CLS_BCAST: hit = mode.all_bcast;
      CLS_MULTI: hit = mode.all_mcast;
      default:   hit = mode.all_ucast | (mode.perfect & match);
    endcase
    hit = hit & mode.en;
    cls = hit ? kind : CLS_REJECT;
  end

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int unsigned CTRL_W    = 32,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned PORT_W    = 16,
  parameter int unsigned MAC_BYTES = 6,
  localparam int unsigned MAC_W    = MAC_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dst_valid,
  input  logic [MAC_W-1:0]  dst_addr,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              data_wr,
  input  logic [PORT_W-1:0] data_wdata,
  output logic              accept,
  output logic [1:0]        dest_class
);

  mode_t            mode;
  logic [MAC_W-1:0] station;
  logic             hit_c;
  dclass_e          cls_c;

  rxf_ctrl_regs #(
    .CTRL_W(CTRL_W), .IDX_W(IDX_W), .PORT_W(PORT_W), .MAC_BYTES(MAC_BYTES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata),
    .mode(mode), .station(station)
  );

  rxf_classify #(.MAC_BYTES(MAC_BYTES)) u_cls (
    .addr(dst_addr), .station(station), .mode(mode),
    .hit(hit_c), .cls(cls_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept     <= 1'b0;
      dest_class <= CLS_REJECT;
    end else if (dst_valid) begin
      accept     <= hit_c;
      dest_class <= cls_c;
    end
  end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int unsigned MAC_W  = 48,
  parameter int unsigned CTRL_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dst_valid,
  input logic [MAC_W-1:0]  dst_addr,
  input logic              ctrl_wr,
  input logic [CTRL_W-1:0] ctrl_wdata,
  input logic              data_wr,
  input logic              accept,
  input logic [1:0]        dest_class,
  input logic              en,
  input logic              aab,
  input logic              aam,
  input logic [3:0]        modes,
  input logic [MAC_W-1:0]  station
);

  AST_DISABLED_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && !en |=> !accept && dest_class == 2'd0); // R3

  AST_BCAST_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && en && aab && (&dst_addr) |=> accept && dest_class == 2'd3); // R4

  AST_MCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid && dst_addr[0] && !(&dst_addr) && !aam |=> !accept); // R5

  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> accept == (dest_class != 2'd0)); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> $stable(accept) && $stable(dest_class)); // R10

  AST_STATION_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en && data_wr |=> $stable(station)); // R8

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    en && ctrl_wr |=> $stable(modes)); // R9

endmodule

bind rx_dest_filter rxf_checker #(.MAC_W(MAC_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .dst_addr(dst_addr),
  .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .data_wr(data_wr),
  .accept(accept), .dest_class(dest_class),
  .en(mode.en), .aab(mode.all_bcast), .aam(mode.all_mcast),
  .modes({mode.all_bcast, mode.all_mcast, mode.all_ucast, mode.perfect}),
  .station(station)
);

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic        data_wr = 1'b0;
  logic [15:0] data_wdata = '0;
  logic        accept;
  logic [1:0]  dest_class;

  int checks = 0;
  int errors = 0;

  // bench model of configuration
  logic        m_en, m_aab, m_aam, m_aau, m_apm;
  logic [9:0]  m_idx;
  logic [47:0] m_sta;

  rx_dest_filter uut (
    .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .data_wr(data_wr),
    .data_wdata(data_wdata), .accept(accept), .dest_class(dest_class)
  );

  always #5 clk = ~clk;

  function automatic logic [1:0] want_class(input logic [47:0] a);
    logic [1:0] k;
    logic ok;
    if (a == 48'hFFFF_FFFF_FFFF) k = 2'd3;
    else if (a[0] == 1'b1)       k = 2'd2;
    else                         k = 2'd1;
    case (k)
      2'd3:    ok = m_aab;
      2'd2:    ok = m_aam;
      default: ok = m_aau || (m_apm && a == m_sta);
    endcase
    return (ok && m_en) ? k : 2'd0;
  endfunction

  task automatic check(input string req, input logic [1:0] exp_cls);
    checks++;
    if (accept !== (exp_cls != 2'd0) || dest_class !== exp_cls) begin
      errors++;
      $display("FAIL %s: accept=%0b class=%0d expected accept=%0b class=%0d",
               req, accept, dest_class, exp_cls != 2'd0, exp_cls);
    end
  endtask

  task automatic ctrl_write(input logic [31:0] w);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_wdata = w;
    @(negedge clk);
    ctrl_wr = 1'b0;
    if (!m_en) begin
      m_en = w[31]; m_aab = w[30]; m_aam = w[29]; m_aau = w[28]; m_apm = w[27];
      m_idx = w[9:0];
    end else m_en = w[31];
  endtask

  task automatic data_write(input logic [15:0] d);
    @(negedge clk);
    data_wr = 1'b1; data_wdata = d;
    @(negedge clk);
    data_wr = 1'b0;
    if (!m_en && m_idx inside {10'd0, 10'd2, 10'd4})
      m_sta[m_idx*8 +: 16] = d;
  endtask

  task automatic frame(input logic [47:0] a, input string req);
    logic [1:0] e;
    e = want_class(a);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = a;
    @(negedge clk);
    dst_valid = 1'b0; dst_addr = ~a;
    check(req, e);
  endtask

  task automatic load_station(input logic [47:0] s);
    for (int k = 0; k < 3; k++) begin
      ctrl_write({5'b0, 17'b0, 10'(2 * k)});
      data_write(s[16*k +: 16]);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] sta;
    void'($urandom(32'h5EED_1234));
    m_en = 0; m_aab = 0; m_aam = 0; m_aau = 0; m_apm = 0; m_idx = '0; m_sta = '0;
    repeat (3) @(negedge clk);
    check("R11 reset", 2'd0);
    rst_n = 1'b1;

    // R3: enable clear, all modes on, still rejects
    ctrl_write(32'h7800_0000);
    frame(48'hFFFF_FFFF_FFFF, "R3 disabled bcast");
    frame(48'h0000_0000_0000, "R3 disabled station-equal");

    // R7: load station, perfect match only
    sta = 48'h5634_12AB_CD02;
    load_station(sta);
    ctrl_write(32'h8800_0000);
    frame(sta, "R7 R6 perfect match");
    frame(sta ^ 48'h0100_0000_0000, "R7 byte5 mismatch");
    frame(48'hFFFF_FFFF_FFFF, "R4 bcast off");
    frame(48'h0000_0000_0001, "R5 mcast off");

    // R8: station write while enabled is ignored
    data_write(16'hBEEF);
    frame(sta, "R8 station kept");

    // R9: mode change while enabled is ignored
    ctrl_write(32'hF000_0000);
    frame(48'hFFFF_FFFF_FFFF, "R9 aab not taken");
    frame(48'h1122_3344_5566, "R9 aau not taken");

    // R10: hold between strobes
    repeat (3) @(negedge clk);
    check("R10 hold", 2'd0);

    // proper sequence: promiscuous via unicast-all
    ctrl_write(32'h0000_0000);
    ctrl_write(32'hF000_0000);
    frame(48'hFFFF_FFFF_FFFF, "R1 R4 bcast class");
    frame(48'h0000_0000_0103, "R1 R5 mcast class");
    frame(48'h1122_3344_5566, "R1 R6 unicast all");

    // R7: odd and out-of-range indices store nothing
    ctrl_write(32'h0000_0000);
    ctrl_write(32'h0000_0001); data_write(16'h1111);
    ctrl_write(32'h0000_0006); data_write(16'h2222);
    ctrl_write(32'h8800_0000);
    frame(sta, "R7 ignored index");

    // random phase
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r == 0) begin
        ctrl_write({$urandom % 2 == 0, 4'($urandom), 17'b0, 10'($urandom % 8)});
      end else if (r == 1) begin
        data_write(16'($urandom));
      end else begin
        logic [47:0] a;
        case ($urandom % 4)
          0: a = 48'hFFFF_FFFF_FFFF;
          1: a = m_sta;
          2: a = m_sta ^ (48'd1 << ($urandom % 48));
          default: a = {16'($urandom), 32'($urandom)};
        endcase
        frame(a, "R1 R2 R6 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule